// File: doc/BRIEF.md
# Ping-Pong Serial/Parallel Link Word Buffer

This block connects a bit-serial link port to a word-parallel processor. The link side runs on its own bit clock, which may have no phase or frequency relation to the processor clock. In the receive direction, arriving bits are packed into 32-bit words. Two word registers take turns: one fills from the line while the other holds a completed word until the processor picks it up. In the transmit direction, the processor writes whole words into a second pair of alternating registers. The link side shifts those words out one bit per bit strobe.

Each word register has a full/empty state. That state is formed by two toggle flags: one flipped by the producing domain and one flipped by the consuming domain. Each flag reaches the opposite clock domain through a two-flop synchronizer. A word register is only written while it is empty, so its contents are stable whenever the other domain sees it as full.

The receive controller has three states. `RX_WAIT` sits between words. On the first valid bit it moves to `RX_FILL` if the target register is empty, or to `RX_DROP` if the target register is still unread. From `RX_FILL` or `RX_DROP` it returns to `RX_WAIT` on the last bit of the word.

The transmit controller also has three states. `TX_WAIT` sits at a word boundary. On a bit strobe it moves to `TX_SEND` if a written word is pending, or to `TX_FILL` if none is. From `TX_SEND` or `TX_FILL` it returns to `TX_WAIT` on the last bit of the word.

Top module: `link_word_buffer`

## Requirements
- R1: Received words are packed most-significant-bit first: the first accepted bit of a word appears at bit 31 of the delivered word, and the 32nd at bit 0.
- R2: `rd_valid` is high exactly while an unread received word is available. `rd_data` shows the oldest unread word. A cycle with `rd_valid` and `rd_ack` both high consumes that word. Words are delivered in arrival order.
- R3: Two complete words can arrive with no processor read in between. Both are kept and delivered, and no overrun is flagged.
- R4: If the first bit of a word arrives while both receive registers hold unread words, that whole word is discarded: it is never delivered, and the stored words are unchanged. On its final bit, `overrun` is set.
- R5: `overrun` stays set until the link-side reset.
- R6: `wr_ready` is high exactly while the next transmit register is free. A write (`wr_valid` with `wr_ready`) stores `wr_data`. At most two written words wait unsent. A write attempted while `wr_ready` is low has no effect on the transmitted stream.
- R7: Transmit words leave most-significant-bit first, one bit per link clock cycle with `tx_bit_en` high. `tx_bit` changes only on such an edge and shows the new bit after it.
- R8: At a word boundary with no written word pending, 32 filler bits are sent in the pattern 1,0,1,0,… (starting with 1) and `underrun` is set. `underrun` stays set until the link-side reset. Words written later are sent normally.
- R9: While `rd_valid` is high and `rd_ack` is low, `rd_valid` stays high and `rd_data` does not change.
- R10: After reset: `rd_valid`=0, `wr_ready`=1, `overrun`=0, `underrun`=0 and `tx_bit`=0.
- R11: Link cycles with `rx_valid` low are ignored, whatever `rx_bit` carries, including pauses in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Processor-side reset, active low, asynchronous |
| lnk_clk | input | 1 | Link bit clock |
| lnk_rst_n | input | 1 | Link-side reset, active low, asynchronous |
| rx_valid | input | 1 | Link domain: `rx_bit` carries a line bit this cycle |
| rx_bit | input | 1 | Link domain: received serial bit |
| rd_valid | output | 1 | Processor domain: an unread received word is available |
| rd_data | output | 32 | Processor domain: oldest unread received word |
| rd_ack | input | 1 | Processor domain: consume the word shown on `rd_data` |
| overrun | output | 1 | Link domain: sticky flag, a received word was dropped |
| wr_valid | input | 1 | Processor domain: `wr_data` offered for transmission |
| wr_data | input | 32 | Processor domain: word to transmit |
| wr_ready | output | 1 | Processor domain: a transmit register is free |
| tx_bit_en | input | 1 | Link domain: emit the next line bit this cycle |
| tx_bit | output | 1 | Link domain: transmitted serial bit, registered |
| underrun | output | 1 | Link domain: sticky flag, filler bits were sent |

## Verification
Assertions check several properties on every cycle of either clock:
- both error flags stay set once raised;
- the bit counters and `tx_bit` hold still when no bit strobe arrives;
- the receive registers stay untouched while a word is being dropped;
- the transmit registers stay untouched by a refused write;
- a pending received word stays steady until it is acknowledged.

The following can only be shown by the directed scenarios, which compare whole words and bit streams against values the bench works out itself:
- bit order within a word;
- delivery order across the ping-pong registers;
- which word is lost in an overrun;
- the filler pattern;
- recovery after an underrun.

// File: rtl/link_buf_pkg.sv
package link_buf_pkg;

    typedef enum logic [1:0] {
        RX_WAIT = 2'd0,
        RX_FILL = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_WAIT = 2'd0,
        TX_SEND = 2'd1,
        TX_FILL = 2'd2
    } tx_state_e;

endpackage

// File: rtl/lb_sync2.sv
module lb_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/lb_rx_pack.sv
module lb_rx_pack
    import link_buf_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              lnk_clk,
    input  logic              lnk_rst_n,
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_bit,
    input  logic              rd_ack,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              overrun
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [1:0][WORD_W-1:0] word_q;
    logic [1:0]             fill_tog, rel_tog, fill_sync, rel_sync;
    logic [1:0]             full_l, full_p;
    logic                   fill_sel, rd_sel;
    logic [CNT_W-1:0]       cnt;
    rx_state_e              state, state_nxt;
    logic                   wr_en, last_bit;

    // Link-side view: a register is full until its release is seen
    assign full_l = fill_tog ^ rel_sync;

    always_comb begin
        last_bit = rx_valid && (cnt == LAST);
        wr_en    = rx_valid && (((state == RX_WAIT) && !full_l[fill_sel]) ||
                                (state == RX_FILL));
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_WAIT: if (rx_valid) state_nxt = full_l[fill_sel] ? RX_DROP : RX_FILL;
            RX_FILL: if (last_bit) state_nxt = RX_WAIT;
            RX_DROP: if (last_bit) state_nxt = RX_WAIT;
            default: state_nxt = RX_WAIT;
        endcase
    end

    always_ff @(posedge lnk_clk or negedge lnk_rst_n) begin
        if (!lnk_rst_n) state <= RX_WAIT;
        else            state <= state_nxt;
    end

    always_ff @(posedge lnk_clk or negedge lnk_rst_n) begin
        if (!lnk_rst_n) begin
            cnt      <= '0;
            fill_sel <= 1'b0;
            fill_tog <= '0;
            word_q   <= '0;
            overrun  <= 1'b0;
        end else begin
            if (rx_valid) cnt <= last_bit ? '0 : cnt + 1'b1;
            if (wr_en) word_q[fill_sel] <= {word_q[fill_sel][WORD_W-2:0], rx_bit};
            if (last_bit && (state == RX_FILL)) begin
                fill_tog[fill_sel] <= ~fill_tog[fill_sel];
                fill_sel           <= ~fill_sel;
            end
            if (last_bit && (state == RX_DROP)) overrun <= 1'b1;
        end
    end

    // Processor side
    lb_sync2 #(.W(2)) u_fill_sync (.clk(clk), .rst_n(rst_n), .d(fill_tog), .q(fill_sync));
    lb_sync2 #(.W(2)) u_rel_sync  (.clk(lnk_clk), .rst_n(lnk_rst_n), .d(rel_tog), .q(rel_sync));

    assign full_p   = fill_sync ^ rel_tog;
    assign rd_valid = full_p[rd_sel];
    assign rd_data  = word_q[rd_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_tog <= '0;
            rd_sel  <= 1'b0;
        end else if (rd_ack && rd_valid) begin
            rel_tog[rd_sel] <= ~rel_tog[rd_sel];
            rd_sel          <= ~rd_sel;
        end
    end

    p_overrun_sticky_r5: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
        overrun |=> overrun);

    p_idle_hold_r11: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
        !rx_valid |=> ($stable(cnt) && $stable(word_q)));

    p_drop_keeps_regs_r4: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
        (state == RX_DROP) |=> $stable(word_q));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !lnk_rst_n)
        (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/lb_tx_unpack.sv
module lb_tx_unpack
    import link_buf_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_clk,
    input  logic              lnk_rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              tx_bit_en,
    output logic              tx_bit,
    output logic              underrun
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [1:0][WORD_W-1:0] word_q;
    logic [1:0]             fill_tog, rel_tog, fill_sync, rel_sync;
    logic [1:0]             full_l, full_p;
    logic                   wr_sel, send_sel;
    logic [CNT_W-1:0]       cnt, bit_idx;
    tx_state_e              state, state_nxt;
    logic                   send_now, next_bit, last_bit;

    // Processor side: write into the next free register
    assign full_p   = fill_tog ^ rel_sync;
    assign wr_ready = !full_p[wr_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            fill_tog <= '0;
            wr_sel   <= 1'b0;
        end else if (wr_valid && wr_ready) begin
            word_q[wr_sel]   <= wr_data;
            fill_tog[wr_sel] <= ~fill_tog[wr_sel];
            wr_sel           <= ~wr_sel;
        end
    end

    lb_sync2 #(.W(2)) u_fill_sync (.clk(lnk_clk), .rst_n(lnk_rst_n), .d(fill_tog), .q(fill_sync));
    lb_sync2 #(.W(2)) u_rel_sync  (.clk(clk), .rst_n(rst_n), .d(rel_tog), .q(rel_sync));

    // Link side
    assign full_l = fill_sync ^ rel_tog;

    always_comb begin
        last_bit = tx_bit_en && (cnt == LAST);
        send_now = (state == TX_WAIT) ? full_l[send_sel] : (state == TX_SEND);
        bit_idx  = LAST - cnt;
        next_bit = send_now ? word_q[send_sel][bit_idx] : ~cnt[0];
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_WAIT: if (tx_bit_en) state_nxt = full_l[send_sel] ? TX_SEND : TX_FILL;
            TX_SEND: if (last_bit)  state_nxt = TX_WAIT;
            TX_FILL: if (last_bit)  state_nxt = TX_WAIT;
            default: state_nxt = TX_WAIT;
        endcase
    end

    always_ff @(posedge lnk_clk or negedge lnk_rst_n) begin
        if (!lnk_rst_n) state <= TX_WAIT;
        else            state <= state_nxt;
    end

    always_ff @(posedge lnk_clk or negedge lnk_rst_n) begin
        if (!lnk_rst_n) begin
            cnt      <= '0;
            tx_bit   <= 1'b0;
            underrun <= 1'b0;
            rel_tog  <= '0;
            send_sel <= 1'b0;
        end else if (tx_bit_en) begin
            cnt    <= last_bit ? '0 : cnt + 1'b1;
            tx_bit <= next_bit;
            if ((state == TX_WAIT) && !send_now) underrun <= 1'b1;
            if (last_bit && send_now) begin
                rel_tog[send_sel] <= ~rel_tog[send_sel];
                send_sel          <= ~send_sel;
            end
        end
    end

    p_tx_hold_r7: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
        !tx_bit_en |=> ($stable(tx_bit) && $stable(cnt)));

    p_underrun_sticky_r8: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
        underrun |=> underrun);

    p_refused_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> $stable(word_q));
endmodule

// File: rtl/link_word_buffer.sv
module link_word_buffer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lnk_clk,
    input  logic              lnk_rst_n,
    input  logic              rx_valid,
    input  logic              rx_bit,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rd_ack,
    output logic              overrun,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              tx_bit_en,
    output logic              tx_bit,
    output logic              underrun
);
    lb_rx_pack #(.WORD_W(WORD_W)) u_rx (
        .lnk_clk   (lnk_clk),
        .lnk_rst_n (lnk_rst_n),
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .rd_ack    (rd_ack),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .overrun   (overrun)
    );

    lb_tx_unpack #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .lnk_clk   (lnk_clk),
        .lnk_rst_n (lnk_rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .tx_bit_en (tx_bit_en),
        .tx_bit    (tx_bit),
        .underrun  (underrun)
    );
endmodule

// File: tb/link_word_buffer_tb.sv
`timescale 1ns/1ps
module link_word_buffer_tb;
    logic        clk = 1'b0, lnk_clk = 1'b0;
    logic        rst_n = 1'b0, lnk_rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_bit = 1'b0, rd_ack = 1'b0;
    logic        wr_valid = 1'b0, tx_bit_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_valid, wr_ready, tx_bit, overrun, underrun;
    logic [31:0] rd_data;
    logic [31:0] cap_q [4];
    int          checks = 0, failures = 0;

    always #10   clk     = ~clk;      // 50 MHz
    always #18.5 lnk_clk = ~lnk_clk;  // unrelated link clock

    link_word_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_rst_n(lnk_rst_n),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_ack(rd_ack), .overrun(overrun), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .tx_bit_en(tx_bit_en), .tx_bit(tx_bit), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Serial word in, MSB first, with a pause holding the wrong bit mid-word (R11)
    task automatic send_rx_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            if (i == 15) begin
                repeat (2) begin
                    @(negedge lnk_clk);
                    rx_valid = 1'b0;
                    rx_bit   = ~w[i];
                end
            end
            @(negedge lnk_clk);
            rx_valid = 1'b1;
            rx_bit   = w[i];
        end
        @(negedge lnk_clk);
        rx_valid = 1'b0;
        rx_bit   = 1'b1;
    endtask

    task automatic read_word(input logic [31:0] exp, input string req);
        int n = 0;
        @(negedge clk);
        while (!rd_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(rd_valid, req, "rd_valid timeout", 32'(rd_valid), 32'd1);
        check(rd_data == exp, req, "rd_data", rd_data, exp);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic tx_capture(input int nw);
        @(negedge lnk_clk);
        tx_bit_en = 1'b1;
        for (int w = 0; w < nw; w++) begin
            for (int b = 0; b < 32; b++) begin
                @(negedge lnk_clk);
                cap_q[w] = {cap_q[w][30:0], tx_bit};
            end
        end
        tx_bit_en = 1'b0;
    endtask

    task automatic t_reset;
        check(rd_valid == 1'b0, "R10", "rd_valid", 32'(rd_valid), 32'd0);
        check(wr_ready == 1'b1, "R10", "wr_ready", 32'(wr_ready), 32'd1);
        check(overrun == 1'b0, "R10", "overrun", 32'(overrun), 32'd0);
        check(underrun == 1'b0, "R10", "underrun", 32'(underrun), 32'd0);
        check(tx_bit == 1'b0, "R10", "tx_bit", 32'(tx_bit), 32'd0);
    endtask

    task automatic t_single_word;  // R1, R2, R11
        send_rx_word(32'hA5C3_0F81);
        read_word(32'hA5C3_0F81, "R1");
        check(rd_valid == 1'b0, "R2", "rd_valid after ack", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_two_words;  // R3, R2 ordering
        send_rx_word(32'h1234_5678);
        send_rx_word(32'hFEDC_BA90);
        read_word(32'h1234_5678, "R3");
        read_word(32'hFEDC_BA90, "R2");
        check(overrun == 1'b0, "R3", "overrun", 32'(overrun), 32'd0);
    endtask

    task automatic t_overrun;  // R4, R5
        send_rx_word(32'h0000_0001);
        send_rx_word(32'h8000_0000);
        send_rx_word(32'h5555_AAAA);
        check(overrun == 1'b1, "R4", "overrun set", 32'(overrun), 32'd1);
        read_word(32'h0000_0001, "R4");
        read_word(32'h8000_0000, "R4");
        repeat (30) @(negedge clk);
        check(rd_valid == 1'b0, "R4", "dropped word absent", 32'(rd_valid), 32'd0);
        send_rx_word(32'hC0DE_F00D);
        read_word(32'hC0DE_F00D, "R5");
        @(negedge lnk_clk);
        check(overrun == 1'b1, "R5", "overrun sticky", 32'(overrun), 32'd1);
    endtask

    task automatic t_transmit;  // R6, R7
        write_word(32'h9ABC_DEF0);
        write_word(32'h0F0F_3C3C);
        check(wr_ready == 1'b0, "R6", "wr_ready both full", 32'(wr_ready), 32'd0);
        wr_valid = 1'b1;
        wr_data  = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        wr_valid = 1'b0;
        repeat (6) @(negedge lnk_clk);
        check(tx_bit == 1'b0, "R7", "tx_bit idle", 32'(tx_bit), 32'd0);
        tx_capture(2);
        check(cap_q[0] == 32'h9ABC_DEF0, "R7", "tx word 0", cap_q[0], 32'h9ABC_DEF0);
        check(cap_q[1] == 32'h0F0F_3C3C, "R6", "tx word 1", cap_q[1], 32'h0F0F_3C3C);
        check(underrun == 1'b0, "R8", "no underrun", 32'(underrun), 32'd0);
        repeat (8) @(negedge clk);
        check(wr_ready == 1'b1, "R6", "wr_ready freed", 32'(wr_ready), 32'd1);
    endtask

    task automatic t_underrun;  // R8, R6 refused write absent
        tx_capture(1);
        check(cap_q[0] == 32'hAAAA_AAAA, "R8", "filler word", cap_q[0], 32'hAAAA_AAAA);
        check(underrun == 1'b1, "R8", "underrun set", 32'(underrun), 32'd1);
        write_word(32'h3141_5926);
        repeat (6) @(negedge lnk_clk);
        tx_capture(1);
        check(cap_q[0] == 32'h3141_5926, "R8", "resume word", cap_q[0], 32'h3141_5926);
        check(underrun == 1'b1, "R8", "underrun sticky", 32'(underrun), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lnk_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_single_word();
        t_two_words();
        t_overrun();
        t_transmit();
        t_underrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule